// File: doc/BRIEF.md
# Hot-Swap Fault Timer and Retry Sequencer

This block is a cycle-based digital stand-in for the fault timer of a hot-swap controller. A saturating accumulator takes the place of the timer capacitor voltage. The full-scale count represents 1.5 V, half scale represents 0.75 V and one third of full scale represents 0.5 V. While the switch runs, the accumulator climbs when the switch is in current limit with its gate below threshold. It climbs faster when the drain sits above the current-limit switch-over level. It decays slowly when the switch is out of current limit.

When the accumulator reaches the trip level, the block raises `timeout`. The trip level is half scale when the drain is above the timer switch-over level and full scale otherwise. After a trip the block runs a fixed sawtooth cool-down of 64 cycles, then empties the accumulator and grants a new start through `restart_ok`. A restart request seen during the cool-down shortens the exit: the accumulator is flushed in one step instead of draining. While `por_release` is low, the block models power-on reset. The accumulator keeps its value, as a capacitor would. When `por_release` rises, the retained level decides between an immediate start and a full cool-down.

Top module: `fault_timer_retry`

## Requirements
- R1: After `rst_n` is released, `timeout`, `restart_ok` and `cycle_count` are all 0 and the accumulator is 0. The block then waits for `por_release`.
- R2: While running, the accumulator changes on each clock as follows. It falls by 2 when `in_current_limit` is 0. It rises by 10 when `in_current_limit` and `gate_below_threshold` are 1 and `drain_above_cl_switch` is 0. It rises by 50 when all three are 1. It holds when `in_current_limit` is 1 and `gate_below_threshold` is 0.
- R3: `timeout` rises, and `restart_ok` falls, on the clock after the update that brings the accumulator to or above the trip level. The trip level is full scale (1536 by default) when `drain_above_timer_switch` is 0 and half scale when it is 1.
- R4: A cool-down cycle is two phases. The accumulator first falls by 2 per clock until it is at or below one third of full scale. It then rises by 10 per clock until it saturates at full scale. `cycle_count` increments each time full scale is reached.
- R5: A cool-down runs exactly 64 cycles. `cycle_count` counts 0 to 63, never exceeds 63, and reads 0 whenever the block is not in the sawtooth.
- R6: Without a restart request, the accumulator falls by 2 per clock from full scale to 0 after the 64th cycle. `timeout` stays high until it arrives at 0, then `restart_ok` rises.
- R7: If `uven_toggle` is 1 on any clock of the sawtooth, including the clock that completes the 64th cycle, the accumulator is cleared in a single clock after the 64th cycle. On the next clock `timeout` falls and `restart_ok` rises.
- R8: While `por_release` is 0, `timeout` and `restart_ok` are 0 one clock later, the accumulator holds its value and `cycle_count` is 0. This override wins over a threshold crossing in the same clock.
- R9: On the clock `por_release` is 1 after being held low, a retained accumulator below one third of full scale leads directly to `restart_ok` with the value kept. A retained value at or above that level starts a full 64-cycle cool-down.
- R10: The accumulator saturates at 0 and at full scale. It never wraps.
- R11: `timeout` and `restart_ok` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| in_current_limit | input | 1 | Switch is regulating its current |
| gate_below_threshold | input | 1 | Gate voltage under its threshold |
| drain_above_cl_switch | input | 1 | Drain above the current-limit switch-over level (fast charge) |
| drain_above_timer_switch | input | 1 | Drain above the timer switch-over level (half-scale trip) |
| uven_toggle | input | 1 | Restart request from the enable input |
| por_release | input | 1 | 0 holds the block in power-on reset |
| timeout | output | 1 | Fault declared, cool-down in progress |
| restart_ok | output | 1 | Running, start permitted |
| cycle_count | output | 7 | Completed cool-down cycles |

## Verification
Two pairs of events can fall in the same clock, and the bench provokes both. The first pair is a restart request on the very clock that completes the 64th sawtooth cycle. The bench uses its reference model to predict that clock and pulses `uven_toggle` there. It then expects the one-clock flush rather than the slow drain. The second pair is a drop of `por_release` on the clock whose update would cross the trip level. The bench requires `timeout` to stay low and, on release, expects a cool-down because the retained level lies above one third of full scale. Constrained random phases cover the rest, with each output compared against the model on every clock.

// File: rtl/ftmr_pkg.sv
package ftmr_pkg;

    typedef enum logic [2:0] {
        ST_POR     = 3'd0,
        ST_RUN     = 3'd1,
        ST_COOL_DN = 3'd2,
        ST_COOL_UP = 3'd3,
        ST_DRAIN   = 3'd4,
        ST_FLUSH   = 3'd5
    } ft_state_e;

    typedef enum logic [2:0] {
        OP_HOLD    = 3'd0,
        OP_DOWN    = 3'd1,
        OP_UP_SLOW = 3'd2,
        OP_UP_FAST = 3'd3,
        OP_CLEAR   = 3'd4
    } acc_op_e;

endpackage

// File: rtl/ftmr_opsel.sv
module ftmr_opsel
    import ftmr_pkg::*;
(
    input  ft_state_e state_q,
    input  logic      por_release,
    input  logic      in_current_limit,
    input  logic      gate_below_threshold,
    input  logic      drain_above_cl_switch,
    output acc_op_e   op
);

    always_comb begin
        op = OP_HOLD;
        if (por_release) begin
            unique case (state_q)
                ST_RUN: begin
                    if (!in_current_limit)         op = OP_DOWN;
                    else if (!gate_below_threshold) op = OP_HOLD;
                    else if (drain_above_cl_switch) op = OP_UP_FAST;
                    else                            op = OP_UP_SLOW;
                end
                ST_COOL_DN, ST_DRAIN: op = OP_DOWN;
                ST_COOL_UP:           op = OP_UP_SLOW;
                ST_FLUSH:             op = OP_CLEAR;
                default:              op = OP_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/ftmr_accum.sv
module ftmr_accum
    import ftmr_pkg::*;
#(
    parameter int FULL_SCALE = 1536,
    parameter int DOWN_STEP  = 2,
    parameter int UP_SLOW    = 10,
    parameter int UP_FAST    = 50,
    parameter int AW         = $clog2(FULL_SCALE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  acc_op_e       op,
    output logic [AW-1:0] acc_next,
    output logic [AW-1:0] acc_q
);

    localparam logic [AW-1:0] FULLV = AW'(FULL_SCALE);
    localparam logic [AW-1:0] DSTEP = AW'(DOWN_STEP);
    localparam logic [AW-1:0] SSTEP = AW'(UP_SLOW);
    localparam logic [AW-1:0] FSTEP = AW'(UP_FAST);

    logic [AW-1:0] acc_d;

    always_comb begin
        acc_d = acc_q;
        unique case (op)
            OP_DOWN:    acc_d = (acc_q > DSTEP) ? acc_q - DSTEP : '0;
            OP_UP_SLOW: acc_d = (acc_q > FULLV - SSTEP) ? FULLV : acc_q + SSTEP;
            OP_UP_FAST: acc_d = (acc_q > FULLV - FSTEP) ? FULLV : acc_q + FSTEP;
            OP_CLEAR:   acc_d = '0;
            default:    acc_d = acc_q;
        endcase
    end

    assign acc_next = acc_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R10: level never leaves [0, full scale]
    a_r10_acc_range: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q <= FULLV);

    // R2 / R8: a hold leaves the level untouched
    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_HOLD |=> $stable(acc_q));

    // R7: flush empties the accumulator in one clock
    a_r7_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_CLEAR |=> acc_q == '0);

endmodule

// File: rtl/ftmr_seq.sv
module ftmr_seq
    import ftmr_pkg::*;
#(
    parameter int FULL_SCALE = 1536,
    parameter int NUM_CYCLES = 64,
    parameter int AW         = $clog2(FULL_SCALE + 1),
    parameter int CW         = $clog2(NUM_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_release,
    input  logic          drain_above_timer_switch,
    input  logic          uven_toggle,
    input  logic [AW-1:0] acc_next,
    input  logic [AW-1:0] acc_q,
    output ft_state_e     state_q,
    output logic          timeout,
    output logic          restart_ok,
    output logic [CW-1:0] cycle_count
);

    localparam logic [AW-1:0] LVL_FULL = AW'(FULL_SCALE);
    localparam logic [AW-1:0] LVL_HALF = AW'(FULL_SCALE / 2);
    localparam logic [AW-1:0] LVL_LOW  = AW'(FULL_SCALE / 3);
    localparam logic [CW-1:0] LAST_CYC = CW'(NUM_CYCLES - 1);

    typedef struct packed {
        ft_state_e     st;
        logic [CW-1:0] cnt;
        logic          tog;
    } seq_t;

    seq_t s_d, s_q;
    logic [AW-1:0] trip_lvl;
    logic          tog_now;

    always_comb begin
        s_d      = s_q;
        trip_lvl = drain_above_timer_switch ? LVL_HALF : LVL_FULL;
        tog_now  = s_q.tog | uven_toggle;
        if (!por_release) begin
            s_d.st  = ST_POR;
            s_d.cnt = '0;
            s_d.tog = 1'b0;
        end else begin
            unique case (s_q.st)
                ST_POR: s_d.st = (acc_q < LVL_LOW) ? ST_RUN : ST_COOL_DN;
                ST_RUN: if (acc_next >= trip_lvl) s_d.st = ST_COOL_DN;
                ST_COOL_DN: begin
                    s_d.tog = tog_now;
                    if (acc_next <= LVL_LOW) s_d.st = ST_COOL_UP;
                end
                ST_COOL_UP: begin
                    s_d.tog = tog_now;
                    if (acc_next == LVL_FULL) begin
                        if (s_q.cnt == LAST_CYC) begin
                            s_d.cnt = '0;
                            s_d.tog = 1'b0;
                            s_d.st  = tog_now ? ST_FLUSH : ST_DRAIN;
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                            s_d.st  = ST_COOL_DN;
                        end
                    end
                end
                ST_DRAIN: if (acc_next == '0) s_d.st = ST_RUN;
                ST_FLUSH: s_d.st = ST_RUN;
                default:  s_d.st = ST_POR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_POR, cnt: '0, tog: 1'b0};
        else        s_q <= s_d;
    end

    assign state_q     = s_q.st;
    assign cycle_count = s_q.cnt;
    assign restart_ok  = (s_q.st == ST_RUN);
    assign timeout     = (s_q.st == ST_COOL_DN) || (s_q.st == ST_COOL_UP) ||
                         (s_q.st == ST_DRAIN)   || (s_q.st == ST_FLUSH);

    // R11: never both flags
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(timeout && restart_ok));

    // R5: counter only moves forward by one or wraps back to zero
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_count != $past(cycle_count) |->
            (cycle_count == $past(cycle_count) + 1'b1) || (cycle_count == '0));

    // R5: counter bounded by the last cycle index
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_count <= LAST_CYC);

    // R8: reset-hold forces both flags low on the next clock
    a_r8_por_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !por_release |=> !timeout && !restart_ok && cycle_count == '0);

endmodule

// File: rtl/fault_timer_retry.sv
module fault_timer_retry
    import ftmr_pkg::*;
#(
    parameter int FULL_SCALE = 1536,
    parameter int NUM_CYCLES = 64,
    parameter int DOWN_STEP  = 2,
    parameter int UP_SLOW    = 10,
    parameter int UP_FAST    = 50,
    localparam int CW        = $clog2(NUM_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_current_limit,
    input  logic          gate_below_threshold,
    input  logic          drain_above_cl_switch,
    input  logic          drain_above_timer_switch,
    input  logic          uven_toggle,
    input  logic          por_release,
    output logic          timeout,
    output logic          restart_ok,
    output logic [CW-1:0] cycle_count
);

    localparam int AW = $clog2(FULL_SCALE + 1);

    ft_state_e     state_q;
    acc_op_e       op;
    logic [AW-1:0] acc_next;
    logic [AW-1:0] acc_q;

    ftmr_opsel u_opsel (
        .state_q              (state_q),
        .por_release          (por_release),
        .in_current_limit     (in_current_limit),
        .gate_below_threshold (gate_below_threshold),
        .drain_above_cl_switch(drain_above_cl_switch),
        .op                   (op)
    );

    ftmr_accum #(
        .FULL_SCALE(FULL_SCALE),
        .DOWN_STEP (DOWN_STEP),
        .UP_SLOW   (UP_SLOW),
        .UP_FAST   (UP_FAST),
        .AW        (AW)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .acc_next(acc_next),
        .acc_q   (acc_q)
    );

    ftmr_seq #(
        .FULL_SCALE(FULL_SCALE),
        .NUM_CYCLES(NUM_CYCLES),
        .AW        (AW),
        .CW        (CW)
    ) u_seq (
        .clk                     (clk),
        .rst_n                   (rst_n),
        .por_release             (por_release),
        .drain_above_timer_switch(drain_above_timer_switch),
        .uven_toggle             (uven_toggle),
        .acc_next                (acc_next),
        .acc_q                   (acc_q),
        .state_q                 (state_q),
        .timeout                 (timeout),
        .restart_ok              (restart_ok),
        .cycle_count             (cycle_count)
    );

endmodule

// File: tb/sim_fault_timer_retry.sv
module sim_fault_timer_retry;

    localparam int FULL = 384;
    localparam int HALF = FULL / 2;
    localparam int LOW  = FULL / 3;
    localparam int NCYC = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_cl = 1'b0, gate_lo = 1'b0, d_cl = 1'b0, d_tmr = 1'b0;
    logic uven = 1'b0, por = 1'b0;
    logic timeout, restart_ok;
    logic [6:0] cycle_count;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    string tag = "R1";
    int max_cnt = 0;

    // model: 0 por, 1 run, 2 cool down, 3 cool up, 4 drain, 5 flush
    int m_st = 0, m_acc = 0, m_cnt = 0;
    bit m_tog = 1'b0;

    fault_timer_retry #(.FULL_SCALE(FULL)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_current_limit(in_cl), .gate_below_threshold(gate_lo),
        .drain_above_cl_switch(d_cl), .drain_above_timer_switch(d_tmr),
        .uven_toggle(uven), .por_release(por),
        .timeout(timeout), .restart_ok(restart_ok), .cycle_count(cycle_count)
    );

    always #4 clk = ~clk;

    function automatic int sat(int v);
        return (v < 0) ? 0 : ((v > FULL) ? FULL : v);
    endfunction

    function automatic int run_step(bit cl, bit gl, bit dc);
        if (!cl) return -2;
        if (!gl) return 0;
        return dc ? 50 : 10;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_acc = 0; m_cnt = 0; m_tog = 1'b0;
        end else if (!por) begin
            m_st = 0; m_cnt = 0; m_tog = 1'b0;
        end else begin
            case (m_st)
                0: m_st = (m_acc < LOW) ? 1 : 2;
                1: begin
                    m_acc = sat(m_acc + run_step(in_cl, gate_lo, d_cl));
                    if (m_acc >= (d_tmr ? HALF : FULL)) m_st = 2;
                end
                2: begin
                    m_tog = m_tog | uven;
                    m_acc = sat(m_acc - 2);
                    if (m_acc <= LOW) m_st = 3;
                end
                3: begin
                    m_tog = m_tog | uven;
                    m_acc = sat(m_acc + 10);
                    if (m_acc == FULL) begin
                        if (m_cnt == NCYC - 1) begin
                            m_cnt = 0;
                            m_st = m_tog ? 5 : 4;
                            m_tog = 1'b0;
                        end else begin
                            m_cnt = m_cnt + 1;
                            m_st = 2;
                        end
                    end
                end
                4: begin
                    m_acc = sat(m_acc - 2);
                    if (m_acc == 0) m_st = 1;
                end
                default: begin
                    m_acc = 0; m_st = 1;
                end
            endcase
        end
    end

    task automatic check_eq(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        check_eq("timeout", int'(timeout), int'(m_st >= 2));
        check_eq("restart_ok", int'(restart_ok), int'(m_st == 1));
        check_eq("cycle_count", int'(cycle_count), m_cnt);
        if (int'(cycle_count) > max_cnt) max_cnt = int'(cycle_count);
    endtask

    task automatic run_until_ok(int limit, bit pulse_at_end);
        for (int i = 0; i < limit; i++) begin
            tick();
            uven = pulse_at_end && m_st == 3 && m_cnt == NCYC - 1 && m_acc + 10 >= FULL;
            if (m_st == 1) break;
        end
        uven = 1'b0;
    endtask

    function automatic int charge_latency(int start, int step, int lvl);
        int n = 0;
        int a = start;
        while (a < lvl) begin a = sat(a + step); n++; end
        return n;
    endfunction

    task automatic measure_trip(string what, int exp);
        int n = 0;
        while (!timeout && n < 1000) begin tick(); n++; end
        check_eq(what, n, exp);
    endtask

    initial begin
        int unsigned seed = $urandom(32'h5EED_0123);
        seed = 0;
        // R1: reset state
        tag = "R1";
        repeat (3) @(negedge clk);
        check_eq("reset timeout", int'(timeout), 0);
        check_eq("reset restart_ok", int'(restart_ok), 0);
        check_eq("reset cycle_count", int'(cycle_count), 0);
        rst_n = 1'b1;
        tick();

        // R8: held in power-on reset, random other inputs
        tag = "R8";
        for (int i = 0; i < 12; i++) begin
            {in_cl, gate_lo, d_cl, d_tmr, uven} = 5'($urandom);
            tick();
        end
        uven = 1'b0;

        // R9: empty accumulator, immediate start
        tag = "R9";
        in_cl = 1'b0; por = 1'b1;
        tick(); tick();
        check_eq("direct start", int'(restart_ok), 1);

        // R2 / R10: decay with floor, then hold
        tag = "R10";
        repeat (20) tick();
        tag = "R2";
        in_cl = 1'b1; gate_lo = 1'b0;
        repeat (8) tick();

        // R3: slow charge to full-scale trip
        tag = "R3";
        gate_lo = 1'b1; d_cl = 1'b0; d_tmr = 1'b0;
        measure_trip("slow trip latency", charge_latency(0, 10, FULL));
        in_cl = 1'b0;

        // R4 / R5 / R6: full cool-down with slow drain
        tag = "R6";
        max_cnt = 0;
        run_until_ok(20000, 1'b0);
        check_eq("R5 last cycle index", max_cnt, NCYC - 1);
        check_eq("R6 restarted", int'(restart_ok), 1);

        // R3: fast charge to half-scale trip
        tag = "R3";
        in_cl = 1'b1; gate_lo = 1'b1; d_cl = 1'b1; d_tmr = 1'b1;
        measure_trip("fast trip latency", charge_latency(0, 50, HALF));
        in_cl = 1'b0;

        // R7: restart request early in cool-down
        tag = "R7";
        repeat (300) tick();
        uven = 1'b1; tick(); uven = 1'b0;
        run_until_ok(20000, 1'b0);
        check_eq("R7 flushed start", int'(restart_ok), 1);

        // R7: restart request on the completing clock
        tag = "R7";
        in_cl = 1'b1;
        measure_trip("fast trip latency 2", charge_latency(0, 50, HALF));
        in_cl = 1'b0;
        run_until_ok(20000, 1'b1);
        check_eq("R7 edge request start", int'(restart_ok), 1);

        // R9: retained level above low mark -> cool-down
        tag = "R9";
        in_cl = 1'b1; gate_lo = 1'b1; d_cl = 1'b0; d_tmr = 1'b0;
        repeat (20) tick();
        in_cl = 1'b0; por = 1'b0;
        tag = "R8";
        repeat (5) tick();
        tag = "R9";
        por = 1'b1;
        tick(); tick();
        check_eq("cool-down after release", int'(timeout), 1);
        run_until_ok(20000, 1'b0);

        // R9: retained level below low mark -> start, level kept
        in_cl = 1'b1; gate_lo = 1'b1; d_cl = 1'b0;
        repeat (10) tick();
        in_cl = 1'b0; por = 1'b0;
        repeat (3) tick();
        por = 1'b1;
        tick(); tick();
        check_eq("kept start", int'(restart_ok), 1);
        in_cl = 1'b1;
        measure_trip("retained trip latency", charge_latency(100 - 2, 10, FULL));
        in_cl = 1'b0;
        run_until_ok(20000, 1'b0);

        // R8: reset-hold on the crossing clock wins
        tag = "R8";
        in_cl = 1'b1; gate_lo = 1'b1; d_cl = 1'b0; d_tmr = 1'b0;
        for (int i = 0; i < 100; i++) begin
            tick();
            if (m_acc + 10 >= FULL) break;
        end
        por = 1'b0;
        tick();
        check_eq("no trip under hold", int'(timeout), 0);
        in_cl = 1'b0; por = 1'b1;
        tick(); tick();
        check_eq("R9 cool-down after hold", int'(timeout), 1);
        run_until_ok(20000, 1'b0);

        // R2 / R11: constrained random
        tag = "R11";
        for (int i = 0; i < 20000; i++) begin
            in_cl   = ($urandom % 100) < 30;
            gate_lo = ($urandom % 100) < 70;
            d_cl    = $urandom % 2;
            d_tmr   = $urandom % 2;
            uven    = ($urandom % 100) < 2;
            por     = ($urandom % 1000) != 0;
            tick();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule